// File: doc/BRIEF.md
# Dataway block-transfer sequencer

This block sits in a crate controller and expands one host command into a burst of Dataway cycles. The command names a station (5 bits), a sub-address (4 bits) and a function code, and selects one of two modes. In repeat mode the same station, sub-address and function are issued again and again for as long as the addressed module answers each cycle with Q=1. In scan mode the address advances after every accepted word. By default the sub-address advances. An option advances the station number instead.

A transfer always ends on one of four conditions. The first is a cycle answered with Q=0. The second is a station scan that wraps to station zero. The third is a sub-address scan that would step past the top sub-address. The fourth is a programmable word limit, which acts as a safety stop. Each word read with Q=1 leaves through a valid/ready stream, and the block does not start another Dataway cycle while that stream is stalled. A busy flag, a cycle counter, a one-cycle completion pulse and a termination code let the host follow the transfer.

Top module: `dw_block_seq`

## Requirements
- R1: A `start` pulse sampled while idle latches the command, and `busy` is high from the next cycle. A `start` sampled while `busy` is high is ignored, and the transfer in progress continues with its latched command.
- R2: In repeat mode (`cmd_scan`=0), every Dataway cycle of a transfer presents the same station, sub-address and function as the command.
- R3: A cycle completed with `dw_q`=0 ends the transfer with `end_cause`=1. Its read data never appears on the output stream.
- R4: `word_count` is cleared when a start is accepted. It adds one for every completed Dataway cycle, the Q=0 cycle included, and it holds its final value until the next accepted start.
- R5: In sub-address scan (`cmd_scan`=1, `cmd_scan_station`=0), the sub-address rises by one after each output word. A word read at sub-address 15 ends the transfer with `end_cause`=3 once it is handed off.
- R6: In station scan (`cmd_scan`=1, `cmd_scan_station`=1), the station rises by one modulo 32 after each output word, and reaching station 0 ends the transfer with `end_cause`=2. A station scan started at station 0 ends at once with no Dataway cycle and a count of 0.
- R7: When an output word is handed off and `word_count` is at least `cmd_max_words`, the transfer ends with `end_cause`=4. A limit of 0 acts as 1. When the limit and a scan end apply to the same word, the limit code is reported.
- R8: Each output word is the `dw_rdata` of a Q=1 cycle, in cycle order. `out_data` is held while `out_valid` is high and `out_ready` is low. `dw_req` is never high together with `out_valid`.
- R9: `xfer_done` is a one-cycle pulse. `end_cause` is valid from that cycle and is held until the next accepted start (0 after reset). `busy` is low in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a transfer when idle |
| cmd_station | input | 5 | Initial station number |
| cmd_subaddr | input | 4 | Initial sub-address |
| cmd_func | input | FUNC_W (5) | Function code issued on every cycle |
| cmd_scan | input | 1 | 0 = repeat mode, 1 = scan mode |
| cmd_scan_station | input | 1 | In scan mode, 1 = step the station, 0 = step the sub-address |
| cmd_max_words | input | CNT_W (16) | Word limit (0 treated as 1) |
| dw_req | output | 1 | Dataway cycle requested, held until `dw_done` |
| dw_station | output | 5 | Station of the current cycle |
| dw_subaddr | output | 4 | Sub-address of the current cycle |
| dw_func | output | FUNC_W (5) | Function of the current cycle |
| dw_rdata | input | DATA_W (24) | Read data, sampled with `dw_done` |
| dw_q | input | 1 | Q response, sampled with `dw_done` |
| dw_done | input | 1 | Cycle complete |
| out_valid | output | 1 | Output word available |
| out_data | output | DATA_W (24) | Output word |
| out_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | Transfer in progress |
| word_count | output | CNT_W (16) | Completed Dataway cycles |
| xfer_done | output | 1 | One-cycle completion pulse |
| end_cause | output | 3 | 0 none, 1 Q=0, 2 station zero, 3 sub-address overflow, 4 word limit |

## Verification
`busy` and the first `dw_req` are due in the cycle right after the clock edge that samples `start`. After the edge that takes a `dw_done`, `dw_req` falls, and in the same cycle either `out_valid` rises or, for a Q=0 cycle, `xfer_done` pulses. After the edge that takes an output handshake, either the next `dw_req` or the `xfer_done` pulse appears, and `busy` falls one cycle later. The bench drives and samples on the falling edge. It checks every Dataway address and every output word against a model-built queue in the cycle where the request or the handshake is seen. It checks the completion values in the first falling edge at which `xfer_done` is high, and `busy` one falling edge later.

// File: rtl/dwbt_pkg.sv
package dwbt_pkg;
  localparam int STN_W = 5;
  localparam int SUB_W = 4;

  typedef enum logic [2:0] {
    END_NONE     = 3'd0,
    END_NOQ      = 3'd1,
    END_STATION  = 3'd2,
    END_ADDR_OVF = 3'd3,
    END_LIMIT    = 3'd4
  } end_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_PUSH,
    ST_FINISH
  } seq_state_e;

  typedef struct packed {
    logic [STN_W-1:0] station;
    logic [SUB_W-1:0] subaddr;
  } dw_addr_t;

  function automatic logic [STN_W-1:0] bump_station(input logic [STN_W-1:0] n);
    return n + 1'b1;
  endfunction

  function automatic logic [SUB_W-1:0] bump_subaddr(input logic [SUB_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic subaddr_at_top(input logic [SUB_W-1:0] a);
    return &a;
  endfunction
endpackage

// File: rtl/dwbt_addr_step.sv
module dwbt_addr_step
  import dwbt_pkg::*;
(
  input  dw_addr_t   cur_addr,
  input  logic       step_station,
  output dw_addr_t   next_addr,
  output logic       scan_ends,
  output end_cause_e scan_cause
);
  always_comb begin
    next_addr  = cur_addr;
    scan_ends  = 1'b0;
    scan_cause = END_NONE;
    if (step_station) begin
      next_addr.station = bump_station(cur_addr.station);
      if (next_addr.station == '0) begin
        scan_ends  = 1'b1;
        scan_cause = END_STATION;
      end
    end else begin
      next_addr.subaddr = bump_subaddr(cur_addr.subaddr);
      if (subaddr_at_top(cur_addr.subaddr)) begin
        scan_ends  = 1'b1;
        scan_cause = END_ADDR_OVF;
      end
    end
  end
endmodule

// File: rtl/dwbt_word_counter.sv
module dwbt_word_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] effective_limit(input logic [CNT_W-1:0] lim);
    return (lim == '0) ? ONE : lim;
  endfunction

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] eff_limit;

  assign eff_limit = effective_limit(limit);
  assign count     = count_q;
  assign at_limit  = (count_q >= eff_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (clear) count_q <= '0;
    else if (bump)  count_q <= count_q + ONE;
  end

  // R7
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= eff_limit);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !bump |=> $stable(count_q));
endmodule

// File: rtl/dwbt_out_stage.sv
module dwbt_out_stage #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              fire
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign valid = valid_q;
  assign data  = data_q;
  assign fire  = valid_q && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= load_data;
    end else if (fire) begin
      valid_q <= 1'b0;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !ready |=> valid_q && $stable(data_q));
endmodule

// File: rtl/dw_block_seq.sv
module dw_block_seq
  import dwbt_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int FUNC_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [4:0]        cmd_station,
  input  logic [3:0]        cmd_subaddr,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic              cmd_scan,
  input  logic              cmd_scan_station,
  input  logic [CNT_W-1:0]  cmd_max_words,
  output logic              dw_req,
  output logic [4:0]        dw_station,
  output logic [3:0]        dw_subaddr,
  output logic [FUNC_W-1:0] dw_func,
  input  logic [DATA_W-1:0] dw_rdata,
  input  logic              dw_q,
  input  logic              dw_done,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              busy,
  output logic [CNT_W-1:0]  word_count,
  output logic              xfer_done,
  output logic [2:0]        end_cause
);
  seq_state_e        state_q;
  dw_addr_t          addr_q;
  logic [FUNC_W-1:0] func_q;
  logic              scan_q;
  logic              scan_st_q;
  logic [CNT_W-1:0]  limit_q;
  end_cause_e        cause_q;

  // Named internal events
  logic       start_accept;
  logic       empty_scan;
  logic       cycle_end;
  logic       cycle_hit;
  logic       word_fire;
  logic       at_limit;
  logic       stream_valid;
  dw_addr_t   next_addr;
  logic       scan_ends;
  end_cause_e scan_cause;

  assign start_accept = (state_q == ST_IDLE) && start;
  assign empty_scan   = cmd_scan && cmd_scan_station && (cmd_station == '0);
  assign cycle_end    = (state_q == ST_ISSUE) && dw_done;
  assign cycle_hit    = cycle_end && dw_q;

  dwbt_addr_step u_step (
    .cur_addr     (addr_q),
    .step_station (scan_st_q),
    .next_addr    (next_addr),
    .scan_ends    (scan_ends),
    .scan_cause   (scan_cause)
  );

  dwbt_word_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_accept),
    .bump     (cycle_end),
    .limit    (limit_q),
    .count    (word_count),
    .at_limit (at_limit)
  );

  dwbt_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cycle_hit),
    .load_data (dw_rdata),
    .ready     (out_ready),
    .valid     (stream_valid),
    .data      (out_data),
    .fire      (word_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      func_q    <= '0;
      scan_q    <= 1'b0;
      scan_st_q <= 1'b0;
      limit_q   <= '0;
      cause_q   <= END_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_accept) begin
            addr_q    <= '{station: cmd_station, subaddr: cmd_subaddr};
            func_q    <= cmd_func;
            scan_q    <= cmd_scan;
            scan_st_q <= cmd_scan_station;
            limit_q   <= cmd_max_words;
            if (empty_scan) begin
              cause_q <= END_STATION;
              state_q <= ST_FINISH;
            end else begin
              cause_q <= END_NONE;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (cycle_end) begin
            if (!dw_q) begin
              cause_q <= END_NOQ;
              state_q <= ST_FINISH;
            end else begin
              state_q <= ST_PUSH;
            end
          end
        end
        ST_PUSH: begin
          if (word_fire) begin
            if (at_limit) begin
              cause_q <= END_LIMIT;
              state_q <= ST_FINISH;
            end else if (scan_q && scan_ends) begin
              cause_q <= scan_cause;
              state_q <= ST_FINISH;
            end else begin
              if (scan_q) addr_q <= next_addr;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign dw_req     = (state_q == ST_ISSUE);
  assign xfer_done  = (state_q == ST_FINISH);
  assign dw_station = addr_q.station;
  assign dw_subaddr = addr_q.subaddr;
  assign dw_func    = func_q;
  assign out_valid  = stream_valid;
  assign end_cause  = cause_q;

  // R1
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !xfer_done |=> $stable(dw_func) && $stable(scan_q) && $stable(limit_q));

  // R2
  repeat_addr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !scan_q && !xfer_done |=> $stable(dw_station) && $stable(dw_subaddr));

  // R3
  noq_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dw_req && dw_done && !dw_q |=> !out_valid && xfer_done);

  // R8
  no_issue_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dw_req && out_valid));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done && !busy && $stable(end_cause));
endmodule

// File: tb/dw_block_seq_tb.sv
module dw_block_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  cmd_station = '0;
  logic [3:0]  cmd_subaddr = '0;
  logic [4:0]  cmd_func = '0;
  logic        cmd_scan = 1'b0;
  logic        cmd_scan_station = 1'b0;
  logic [15:0] cmd_max_words = '0;
  logic        dw_req;
  logic [4:0]  dw_station;
  logic [3:0]  dw_subaddr;
  logic [4:0]  dw_func;
  logic [23:0] dw_rdata = '0;
  logic        dw_q = 1'b0;
  logic        dw_done = 1'b0;
  logic        out_valid;
  logic [23:0] out_data;
  logic        out_ready = 1'b1;
  logic        busy;
  logic [15:0] word_count;
  logic        xfer_done;
  logic [2:0]  end_cause;

  always #4 clk = ~clk;

  dw_block_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_station(cmd_station), .cmd_subaddr(cmd_subaddr), .cmd_func(cmd_func),
    .cmd_scan(cmd_scan), .cmd_scan_station(cmd_scan_station),
    .cmd_max_words(cmd_max_words),
    .dw_req(dw_req), .dw_station(dw_station), .dw_subaddr(dw_subaddr),
    .dw_func(dw_func), .dw_rdata(dw_rdata), .dw_q(dw_q), .dw_done(dw_done),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .word_count(word_count), .xfer_done(xfer_done),
    .end_cause(end_cause)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference queues built by the behavioural model
  logic [8:0]  exp_addr[$];
  logic [23:0] exp_word[$];
  logic [4:0]  func_g = '0;
  int          qlen_g = 0;
  int          dw_idx = 0;
  int          lat = 0;
  bit          stall_g = 0;
  int          cyc = 0;
  string       req_g = "R2";

  // Module responder, stream sink and per-clock comparison
  always @(negedge clk) begin
    cyc++;
    if (dw_done) begin
      dw_done = 1'b0;
    end else if (rst_n && dw_req) begin
      lat++;
      if (lat >= 2) begin
        lat = 0;
        if (exp_addr.size() == 0) begin
          check(0, req_g, "unexpected Dataway cycle", {dw_station, dw_subaddr}, -1);
        end else begin
          logic [8:0] e;
          e = exp_addr.pop_front();
          check({dw_station, dw_subaddr} == e, req_g, "cycle address",
                {dw_station, dw_subaddr}, e);
        end
        check(dw_func == func_g, "R2", "cycle function", dw_func, func_g);
        dw_q     = (dw_idx < qlen_g);
        dw_rdata = {dw_station, dw_subaddr, 15'(dw_idx)};
        dw_done  = 1'b1;
        dw_idx++;
      end
    end
    out_ready = stall_g ? ((cyc % 3) != 0) : 1'b1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_word.size() == 0) begin
        check(0, "R3", "unexpected output word", out_data, -1);
      end else begin
        logic [23:0] w;
        w = exp_word.pop_front();
        check(out_data == w, "R8", "output word", out_data, w);
      end
    end
    if (rst_n && dw_req && out_valid)
      check(0, "R8", "request while output pending", 1, 0);
  end

  task automatic run(input bit scan, input bit st, input logic [4:0] n,
                     input logic [3:0] a, input logic [4:0] f, input int max,
                     input int qlen, input bit stall, input bit poke,
                     input string req);
    logic [4:0] mn;
    logic [3:0] ma;
    int cnt, idx, effmax, cause, guard;
    mn = n; ma = a; cnt = 0; idx = 0; cause = 0;
    effmax = (max == 0) ? 1 : max;
    exp_addr.delete();
    exp_word.delete();
    if (scan && st && mn == 0) begin
      cause = 2;
    end else begin
      while (1) begin
        exp_addr.push_back({mn, ma});
        cnt++;
        if (idx >= qlen) begin cause = 1; break; end
        exp_word.push_back({mn, ma, 15'(idx)});
        if (cnt >= effmax) begin cause = 4; break; end
        if (scan) begin
          if (st) begin
            mn = mn + 5'd1;
            if (mn == 0) begin cause = 2; break; end
          end else begin
            if (ma == 4'hF) begin cause = 3; break; end
            ma = ma + 4'd1;
          end
        end
        idx++;
      end
    end
    func_g = f; qlen_g = qlen; dw_idx = 0; lat = 0; stall_g = stall; req_g = req;
    @(negedge clk);
    cmd_station = n; cmd_subaddr = a; cmd_func = f; cmd_scan = scan;
    cmd_scan_station = st; cmd_max_words = 16'(max); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      cmd_station = 5'd3; cmd_subaddr = 4'd9; cmd_func = 5'd30;
      cmd_scan = 1'b1; cmd_scan_station = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!xfer_done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(xfer_done == 1'b1, "R9", "completion pulse seen", xfer_done, 1);
    check(end_cause == 3'(cause), req, "end cause", end_cause, cause);
    check(word_count == 16'(cnt), "R4", "cycle count", word_count, cnt);
    check(exp_addr.size() == 0, req, "cycles missing", exp_addr.size(), 0);
    check(exp_word.size() == 0, "R8", "words missing", exp_word.size(), 0);
    @(negedge clk);
    check(!busy && !xfer_done, "R9", "idle after pulse", {busy, xfer_done}, 0);
    check(end_cause == 3'(cause), "R9", "cause held", end_cause, cause);
    check(word_count == 16'(cnt), "R4", "count held", word_count, cnt);
  endtask

  initial begin
    #1200000;
    check(0, "R9", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !dw_req && !out_valid && !xfer_done, "R9", "reset outputs",
          {busy, dw_req, out_valid, xfer_done}, 0);
    check(word_count == 0, "R4", "reset count", word_count, 0);
    check(end_cause == 0, "R9", "reset cause", end_cause, 0);
    // R2 R3: repeat, module drops Q after five words
    run(0, 0, 5'd7, 4'd2, 5'd0, 100, 5, 0, 0, "R3");
    // R1 R8: repeat with stalls and a start while busy
    run(0, 0, 5'd12, 4'd5, 5'd2, 100, 8, 1, 1, "R1");
    // R5: sub-address scan runs off the top
    run(1, 0, 5'd4, 4'd12, 5'd1, 100, 50, 0, 0, "R5");
    // R5 R3: sub-address scan ended by Q
    run(1, 0, 5'd4, 4'd0, 5'd1, 100, 2, 1, 0, "R5");
    // R6: station scan wraps to zero
    run(1, 1, 5'd29, 4'd3, 5'd16, 100, 50, 0, 0, "R6");
    // R6: station scan from station zero
    run(1, 1, 5'd0, 4'd3, 5'd16, 100, 50, 0, 0, "R6");
    // R7: word limit in repeat mode
    run(0, 0, 5'd9, 4'd9, 5'd8, 3, 10, 1, 0, "R7");
    // R7: limit wins over sub-address overflow
    run(1, 0, 5'd9, 4'd14, 5'd8, 2, 10, 0, 0, "R7");
    // R7: limit of zero acts as one
    run(0, 0, 5'd1, 4'd1, 5'd4, 0, 10, 0, 0, "R7");
    // R3: first cycle already answered with Q=0
    run(0, 0, 5'd2, 4'd6, 5'd4, 100, 0, 0, 0, "R3");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule